// File: doc/BRIEF.md
# Repeated-Subtraction Sequential Divider

This block divides one unsigned integer by another by counting subtractions. A start request captures the dividend into a working register, captures the divisor, and clears a quotient counter. On each following clock cycle the divisor is taken away from the working value once, provided the working value is not smaller than the divisor, and the counter goes up by one. When the working value drops below the divisor, the counter holds the quotient and the working register holds the remainder.

Latency depends on the data. A run with quotient Q takes Q+1 compute cycles: Q subtracting cycles and one cycle that finds no further subtraction possible. This suits places where area matters more than speed and operands are small. A zero divisor is caught at start. It completes at once with an error flag and fixed results.

Top module: `rsub_divider`

## Requirements
- R1: After reset, busy_o, done_o and div_zero_o are 0 and quotient_o and remainder_o are 0.
- R2: A start_i sampled while busy_o is 0 with a nonzero divisor_i sets busy_o on the next clock edge and clears div_zero_o.
- R3: On completion with a nonzero divisor, quotient_o equals dividend_i / divisor_i and remainder_o equals dividend_i % divisor_i for the operands sampled with start_i. Both use unsigned integer division.
- R4: When the dividend is an exact multiple of the divisor, remainder_o is 0 and the final subtraction is counted in quotient_o.
- R5: When the dividend is smaller than the divisor, quotient_o is 0 and remainder_o equals the dividend after a single compute cycle.
- R6: With a nonzero divisor, done_o goes high Q+1 clock edges after the edge that samples start_i, where Q is the quotient. It stays high for exactly one cycle, and busy_o is 0 while done_o is 1.
- R7: A start_i sampled with divisor_i equal to 0 raises done_o and div_zero_o on that same edge. In that case quotient_o is all ones, remainder_o equals the dividend, and busy_o never rises.
- R8: start_i is ignored while busy_o is 1. The running division completes with its original operands and its original latency.
- R9: After done_o, quotient_o, remainder_o and div_zero_o hold their values until the next accepted start_i, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a division; honoured only while idle |
| dividend_i | input | WIDTH | Unsigned dividend, sampled with start_i |
| divisor_i | input | WIDTH | Unsigned divisor, sampled with start_i |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | WIDTH | Quotient (subtraction count) |
| remainder_o | output | WIDTH | Remainder (working value) |
| div_zero_o | output | 1 | Last accepted start had a zero divisor |

## Verification
On every cycle, the assertions check the following:
- done_o is a single-cycle pulse and never coincides with busy_o.
- The quotient counter moves by at most one per compute cycle.
- An accepted start leads on the next edge to busy_o, or to the zero-divisor completion.
- A completed nonzero division leaves a remainder below the captured divisor.

Only the bench scenarios can show the following, because they need the operands and the cycle count of a whole run:
- The quotient and remainder values match integer division.
- The exact latency of Q+1 edges holds.
- A start during a run has no effect.
- Results hold after completion.

// File: rtl/rsub_div_pkg.sv
package rsub_div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/rsub_div_step.sv
module rsub_div_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] work_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic             ge_o,
  output logic [WIDTH-1:0] diff_o
);
  logic [WIDTH:0] ext_diff;

  // borrow out of the extended subtraction means work < dvs
  assign ext_diff = {1'b0, work_i} - {1'b0, dvs_i};
  assign ge_o     = ~ext_diff[WIDTH];
  assign diff_o   = ext_diff[WIDTH-1:0];
endmodule

// File: rtl/rsub_div_ctrl.sv
module rsub_div_ctrl
  import rsub_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dvs_zero_i,
  input  logic ge_i,
  output logic load_o,
  output logic zero_load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o,
  output logic div_zero_o
);
  div_state_e state_q, state_d;
  logic       done_d, dz_d;
  logic       done_q, dz_q;

  always_comb begin
    state_d     = state_q;
    done_d      = 1'b0;
    dz_d        = dz_q;
    load_o      = 1'b0;
    zero_load_o = 1'b0;
    step_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          if (dvs_zero_i) begin
            zero_load_o = 1'b1;
            done_d      = 1'b1;
            dz_d        = 1'b1;
          end else begin
            state_d = ST_RUN;
            dz_d    = 1'b0;
          end
        end
      end
      ST_RUN: begin
        if (ge_i) begin
          step_o = 1'b1;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      dz_q    <= dz_d;
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign div_zero_o = dz_q;
endmodule

// File: rtl/rsub_div_datapath.sv
module rsub_div_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             zero_load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             ge_o,
  output logic [WIDTH-1:0] work_o,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] dvs_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] work_q, count_q, dvs_q, diff;

  rsub_div_step #(.WIDTH(WIDTH)) u_step (
    .work_i (work_q),
    .dvs_i  (dvs_q),
    .ge_o   (ge_o),
    .diff_o (diff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q  <= '0;
      count_q <= '0;
      dvs_q   <= '0;
    end else if (load_i) begin
      work_q  <= dividend_i;
      dvs_q   <= divisor_i;
      count_q <= zero_load_i ? ALL_ONES : '0;
    end else if (step_i) begin
      work_q  <= diff;
      count_q <= count_q + ONE;
    end
  end

  assign work_o  = work_q;
  assign count_o = count_q;
  assign dvs_o   = dvs_q;
endmodule

// File: rtl/rsub_divider.sv
module rsub_divider #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             div_zero_o
);
  logic load, zero_load, step, ge;
  logic [WIDTH-1:0] dvs_q;

  rsub_div_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dvs_zero_i  (divisor_i == '0),
    .ge_i        (ge),
    .load_o      (load),
    .zero_load_o (zero_load),
    .step_o      (step),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .div_zero_o  (div_zero_o)
  );

  rsub_div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .zero_load_i (zero_load),
    .step_i      (step),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .ge_o        (ge),
    .work_o      (remainder_o),
    .count_o     (quotient_o),
    .dvs_o       (dvs_q)
  );
endmodule

// File: rtl/rsub_div_checker.sv
module rsub_div_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o,
  input logic             div_zero_o,
  input logic [WIDTH-1:0] dvs_q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_not_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i != '0) |=> (busy_o && !div_zero_o));

  p_zero_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i == '0) |=> (done_o && div_zero_o && !busy_o && (&quotient_o)));

  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      (quotient_o == $past(quotient_o) || quotient_o == $past(quotient_o) + ONE));

  p_rem_below_dvs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> (remainder_o < dvs_q));

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

bind rsub_divider rsub_div_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .divisor_i   (divisor_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .div_zero_o  (div_zero_o),
  .dvs_q       (dvs_q)
);

// File: tb/sim_rsub_divider.sv
`timescale 1ns/1ps
module sim_rsub_divider;
  localparam int W = 8;
  localparam int WD_LIMIT = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         busy, done, dz;
  logic [W-1:0] q, r;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rsub_divider #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(a), .divisor_i(b),
    .busy_o(busy), .done_o(done), .quotient_o(q),
    .remainder_o(r), .div_zero_o(dz)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog R6: cycles %0d expected below %0d", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // start one division at a negedge; wait for done; lat = negedges until done seen
  task automatic run_div(input int da, input int db, input bit poke,
                         output int lat, output bit busy_at_done);
    a = W'(da); b = W'(db); start = 1'b1;
    lat = 0;
    busy_at_done = 1'b0;
    forever begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        start = 1'b0;
        a = W'(da ^ 8'h5a); b = W'(db + 3);
      end
      if (poke && lat == 3) begin
        start = 1'b1; a = 8'd9; b = 8'd1;
      end
      if (poke && lat == 4) start = 1'b0;
      if (done) begin
        busy_at_done = busy;
        break;
      end
      if (lat > 2000) break;
    end
  endtask

  task automatic check_div(input int da, input int db, input string req, input bit poke);
    int lat, eq, er, elat;
    bit bd;
    run_div(da, db, poke, lat, bd);
    if (db == 0) begin
      eq = (1 << W) - 1; er = da; elat = 1;
      chk(dz == 1'b1, "R7", "div_zero flag", int'(dz), 1);
    end else begin
      eq = da / db; er = da % db; elat = eq + 2;
      chk(dz == 1'b0, req, "div_zero flag", int'(dz), 0);
    end
    chk(int'(q) == eq, req, $sformatf("quotient %0d/%0d", da, db), int'(q), eq);
    chk(int'(r) == er, req, $sformatf("remainder %0d/%0d", da, db), int'(r), er);
    chk(lat == elat, "R6", $sformatf("latency %0d/%0d", da, db), lat, elat);
    chk(bd == 1'b0, "R6", "busy with done", int'(bd), 0);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done single pulse", int'(done), 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && dz == 0, "R1", "control outputs", {busy, done, dz}, 0);
    chk(q == 0 && r == 0, "R1", "result outputs", int'({q, r}), 0);
  endtask

  task automatic t_start_busy();
    a = 8'd20; b = 8'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    chk(dz == 1'b0, "R2", "flag cleared", int'(dz), 0);
    while (!done) @(negedge clk);
    chk(q == 5 && r == 0, "R2", "result 20/4", int'(q), 5);
    @(negedge clk);
  endtask

  task automatic t_basic();
    check_div(143, 11, "R3", 1'b0);
    check_div(255, 1, "R3", 1'b0);
    check_div(200, 7, "R3", 1'b0);
    check_div(100, 99, "R3", 1'b0);
  endtask

  task automatic t_exact();
    check_div(60, 12, "R4", 1'b0);
    check_div(255, 255, "R4", 1'b0);
    check_div(0, 5, "R4", 1'b0);
  endtask

  task automatic t_small();
    check_div(3, 200, "R5", 1'b0);
    check_div(254, 255, "R5", 1'b0);
  endtask

  task automatic t_zero();
    bit saw_busy = 1'b0;
    a = 8'd77; b = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    saw_busy = busy;
    chk(done == 1'b1, "R7", "done same edge", int'(done), 1);
    chk(dz == 1'b1, "R7", "div_zero", int'(dz), 1);
    chk(q == 8'hff, "R7", "quotient all ones", int'(q), 255);
    chk(r == 8'd77, "R7", "remainder dividend", int'(r), 77);
    chk(saw_busy == 1'b0, "R7", "no busy", int'(saw_busy), 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", "idle after", {done, busy}, 0);
    check_div(0, 0, "R7", 1'b0);
  endtask

  task automatic t_ignore_start();
    check_div(200, 3, "R8", 1'b1);
  endtask

  task automatic t_hold();
    check_div(91, 8, "R9", 1'b0);
    for (int i = 0; i < 6; i++) begin
      a = W'(i * 37); b = W'(i);
      @(negedge clk);
    end
    chk(q == 11 && r == 3, "R9", "results held", int'({q, r}), int'({8'd11, 8'd3}));
    chk(dz == 1'b0 && done == 1'b0, "R9", "flags held", {dz, done}, 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) begin
      int ra = $urandom_range(255, 0);
      int rb = (i % 10 == 0) ? 0 : $urandom_range(255, 0);
      check_div(ra, rb, "R3", 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h1d2c));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_busy();
    t_basic();
    t_exact();
    t_small();
    t_zero();
    t_ignore_start();
    t_hold();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule